// File: doc/BRIEF.md
# Streaming Data Bus Grant Controller

This block sits on the system side of a shared data bus and hands data-bus ownership to several masters in turn. Each master presents the tenure at the head of its queue: a request line and two qualifiers giving direction (read or write) and length (a four-beat burst or a single beat). The controller pulses a one-cycle grant to the chosen master. It then acknowledges the beats of that tenure whenever the data source signals it is ready, which lets it insert wait states between beats. It reports completion on the final beat.

Ownership normally changes with a bubble: after the last beat there is one idle cycle, then a grant cycle. When the finishing tenure is a burst read and the master picked next also offers a burst read, the next grant is issued in the same cycle as the final beat. The new tenure then follows with no dead cycle, even when the two masters differ. A streamed tenure has no buffering to undo data late. Its first beat is therefore held until the address-retry window has opened, which is one cycle later than a normal tenure's earliest first beat.

The retry window is counted per master from the cycle its request rises (the end of its address phase). The counter restarts when the master's tenure completes.

Top module: `dbg_stream_ctrl`

## Requirements
- R1: While rst_ni is low and in the first cycle after release with no request, dbg_o, ta_o, cmp_o and strm_o are all zero.
- R2: From the idle state, the grant goes to the first requesting master found in circular order, starting one past the master granted most recently (master 0 first after reset). dbg_o is one-hot for exactly one cycle.
- R3: A tenure with req_burst_i=1 completes after four acknowledged beats and one with req_burst_i=0 after one. cmp_o pulses on the owner's bit in the cycle of the last ta_o.
- R4: ta_o is high only while a tenure is active and data_rdy_i is high. With data_rdy_i low the beat count holds, which gives a wait state.
- R5: If the finishing tenure and the next selected tenure are both burst reads (req_rd_i=1, req_burst_i=1), the next grant is asserted in the same cycle as the finishing tenure's last ta_o.
- R6: Any other handoff leaves exactly one cycle with no grant and no acknowledge after the last beat. The grant decision is made in the cycle after that.
- R7: In a non-streamed tenure, the first beat may be acknowledged once the owner's retry counter has reached RETRY_START-1. The counter is 0 in the cycle the request rises and advances by one per cycle.
- R8: In a streamed tenure (strm_o=1), the first beat is not acknowledged before the owner's retry counter reaches RETRY_START.
- R9: When choosing a streaming successor, the current owner is excluded. The pick is the first other requesting master in circular order after the owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_MST | Master has a pending data tenure; held until its cmp_o bit |
| req_rd_i | input | N_MST | Pending tenure is a read (1) or a write (0) |
| req_burst_i | input | N_MST | Pending tenure is a four-beat burst (1) or a single beat (0) |
| data_rdy_i | input | 1 | Data source can complete a beat this cycle |
| dbg_o | output | N_MST | One-cycle data bus grant, one bit per master |
| ta_o | output | 1 | Beat acknowledge |
| cmp_o | output | N_MST | Tenure completed on this beat, one bit per master |
| strm_o | output | 1 | Current tenure was granted by streaming |

## Verification
A bad beat counter shows up at cmp_o within one tenure: the completion pulse comes early or late, and the grant that follows shifts with it. A stale owner or round-robin pointer gives a grant on the wrong dbg_o bit at the very next handoff. A wrong streaming flag moves the first ta_o of the new tenure by one cycle against the retry-window edge, so the bench deliberately places requests just before streaming handoffs to land on that edge. The reference model compares every output on every cycle, so any such error is reported in the cycle it first appears.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_GAP  = 2'd2
  } dbg_state_e;

  typedef struct packed {
    logic rd;
    logic burst;
  } tenure_t;
endpackage

// File: rtl/dbg_rr_arb.sv
module dbg_rr_arb #(
  parameter int N_MST = 4,
  localparam int IW = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic [N_MST-1:0] req_i,
  input  logic [N_MST-1:0] mask_i,
  input  logic [IW-1:0]    last_i,
  output logic             vld_o,
  output logic [IW-1:0]    idx_o
);
  int c;

  // circular search starting one past the last grant
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    c     = 0;
    for (int k = 1; k <= N_MST; k++) begin
      c = (int'(last_i) + k) % N_MST;
      if (!vld_o && req_i[c] && !mask_i[c]) begin
        vld_o = 1'b1;
        idx_o = IW'(c);
      end
    end
  end
endmodule

// File: rtl/dbg_age_track.sv
module dbg_age_track #(
  parameter int N_MST       = 4,
  parameter int RETRY_START = 4,
  localparam int AW = $clog2(RETRY_START + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_MST-1:0]           req_i,
  input  logic [N_MST-1:0]           clr_i,
  output logic [N_MST-1:0][AW-1:0]   age_o
);
  for (genvar g = 0; g < N_MST; g++) begin : g_age
    logic [AW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     cnt_q <= '0;
      else if (!req_i[g] || clr_i[g])  cnt_q <= '0;
      else if (cnt_q != AW'(RETRY_START)) cnt_q <= cnt_q + 1'b1;
    end

    assign age_o[g] = cnt_q;

    a_r7_age_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= AW'(RETRY_START));

    a_r7_age_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] || !req_i[g]) |=> (cnt_q == '0));
  end
endmodule

// File: rtl/dbg_beat_ctr.sv
module dbg_beat_ctr #(
  parameter int BURST_BEATS = 4,
  localparam int BW = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic          burst_i,
  output logic [BW-1:0] beat_o,
  output logic          last_o
);
  logic [BW-1:0] beat_q;

  assign last_o = burst_i ? (beat_q == BW'(BURST_BEATS - 1)) : 1'b1;
  assign beat_o = beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       beat_q <= '0;
    else if (load_i || (adv_i && last_o)) beat_q <= '0;
    else if (adv_i)                    beat_q <= beat_q + 1'b1;
  end

  a_r3_beat_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_q < BW'(BURST_BEATS) || BURST_BEATS == (1 << BW));

  a_r4_hold_on_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !load_i) |=> $stable(beat_q));
endmodule

// File: rtl/dbg_stream_ctrl.sv
module dbg_stream_ctrl
  import dbg_pkg::*;
#(
  parameter int N_MST       = 4,
  parameter int BURST_BEATS = 4,
  parameter int RETRY_START = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_MST-1:0] req_i,
  input  logic [N_MST-1:0] req_rd_i,
  input  logic [N_MST-1:0] req_burst_i,
  input  logic             data_rdy_i,
  output logic [N_MST-1:0] dbg_o,
  output logic             ta_o,
  output logic [N_MST-1:0] cmp_o,
  output logic             strm_o
);
  localparam int IW = (N_MST > 1) ? $clog2(N_MST) : 1;
  localparam int AW = $clog2(RETRY_START + 1);
  localparam int BW = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;

  dbg_state_e                 state_q, state_d;
  logic [IW-1:0]              own_q, last_q;
  tenure_t                    cur_q;
  logic                       strm_q;
  logic [N_MST-1:0][AW-1:0]   age;
  logic [N_MST-1:0]           arb_mask;
  logic                       arb_vld;
  logic [IW-1:0]              arb_idx;
  logic [BW-1:0]              beat;
  logic                       beat_last;
  logic [AW-1:0]              age_cur, thr;
  logic                       win_ok, ta, last_beat, stream_go, grant_idle, load;

  // owner is masked while a tenure runs: only others may stream in
  assign arb_mask = (state_q == ST_XFER) ? (N_MST'(1) << own_q) : '0;

  dbg_rr_arb #(.N_MST(N_MST)) i_arb (
    .req_i  (req_i),
    .mask_i (arb_mask),
    .last_i (last_q),
    .vld_o  (arb_vld),
    .idx_o  (arb_idx)
  );

  dbg_age_track #(.N_MST(N_MST), .RETRY_START(RETRY_START)) i_age (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .clr_i  (cmp_o),
    .age_o  (age)
  );

  dbg_beat_ctr #(.BURST_BEATS(BURST_BEATS)) i_beat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .adv_i   (ta),
    .burst_i (cur_q.burst),
    .beat_o  (beat),
    .last_o  (beat_last)
  );

  assign age_cur = age[own_q];
  // streamed tenures wait one cycle longer: no late-cancel buffering
  assign thr     = strm_q ? AW'(RETRY_START) : AW'(RETRY_START - 1);
  assign win_ok  = (beat != '0) || (age_cur >= thr);

  assign ta         = (state_q == ST_XFER) && data_rdy_i && win_ok;
  assign last_beat  = ta && beat_last;
  assign stream_go  = last_beat && cur_q.rd && cur_q.burst && arb_vld &&
                      req_rd_i[arb_idx] && req_burst_i[arb_idx];
  assign grant_idle = (state_q == ST_IDLE) && arb_vld;
  assign load       = grant_idle || stream_go;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (grant_idle) state_d = ST_XFER;
      ST_XFER: if (last_beat)  state_d = stream_go ? ST_XFER : ST_GAP;
      ST_GAP:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      own_q   <= '0;
      last_q  <= IW'(N_MST - 1);
      cur_q   <= '0;
      strm_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load) begin
        own_q    <= arb_idx;
        last_q   <= arb_idx;
        cur_q.rd    <= req_rd_i[arb_idx];
        cur_q.burst <= req_burst_i[arb_idx];
        strm_q   <= stream_go;
      end
    end
  end

  assign dbg_o  = load ? (N_MST'(1) << arb_idx) : '0;
  assign ta_o   = ta;
  assign cmp_o  = last_beat ? (N_MST'(1) << own_q) : '0;
  assign strm_o = (state_q == ST_XFER) && strm_q;

  a_r2_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dbg_o));

  a_r2_grant_requested: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dbg_o) |-> (|(dbg_o & req_i)));

  a_r4_ta_needs_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ta_o |-> data_rdy_i);

  a_r3_cmp_on_ta: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cmp_o) |-> ta_o);

  a_r5_stream_only_burst_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|dbg_o) && (|cmp_o)) |-> (cur_q.rd && cur_q.burst && (|(dbg_o & req_rd_i & req_burst_i))));

  a_r6_gap_after_plain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|cmp_o) && !(|dbg_o)) |=> (!(|dbg_o) && !ta_o));

  a_r8_strm_first_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ta_o && strm_o && beat == '0) |-> (age_cur >= AW'(RETRY_START)));

  a_r9_owner_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_XFER && (|dbg_o)) |-> !dbg_o[own_q]);
endmodule

// File: tb/test_dbg_stream_ctrl.sv
module test_dbg_stream_ctrl;
  localparam int N   = 4;
  localparam int BTS = 4;
  localparam int RS  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0, rd = '0, bu = '0;
  logic rdy = 1'b0;
  logic [N-1:0] dbg, cmp;
  logic ta, strm;

  always #5 clk = ~clk;

  dbg_stream_ctrl #(.N_MST(N), .BURST_BEATS(BTS), .RETRY_START(RS)) i_dbg_stream_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_rd_i(rd), .req_burst_i(bu),
    .data_rdy_i(rdy), .dbg_o(dbg), .ta_o(ta), .cmp_o(cmp), .strm_o(strm)
  );

  int n_chk = 0, n_fail = 0;
  bit qrd[N][$];
  bit qbu[N][$];
  int rdy_mode = 0;

  // reference model state
  int ms = 0, mown = 0, mlast = N - 1, mbeat = 0;
  bit mstrm = 0, mrd = 0, mburst = 0;
  int mage[N];
  int n_stream = 0, n_gap = 0, n_wait = 0, hit_std = 0, hit_str = 0, n_single = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic int pick(logic [N-1:0] rq, int own);
    for (int k = 1; k <= N; k++) begin
      int c = (mlast + k) % N;
      if (rq[c] && c != own) return c;
    end
    return -1;
  endfunction

  task automatic push(int m, bit r, bit b);
    qrd[m].push_back(r);
    qbu[m].push_back(b);
  endtask

  task automatic step();
    logic [N-1:0] e_dbg, e_cmp;
    bit e_ta, e_strm, grant, go_str, fin;
    int p;
    @(negedge clk);
    for (int m = 0; m < N; m++) begin
      req[m] = qrd[m].size() > 0;
      rd[m]  = req[m] ? qrd[m][0] : 1'b0;
      bu[m]  = req[m] ? qbu[m][0] : 1'b0;
    end
    rdy = (rdy_mode == 0) ? 1'b1 : (($urandom % 4) != 0);
    #1;
    e_dbg = '0; e_cmp = '0; e_ta = 0; grant = 0; go_str = 0; fin = 0; p = -1;
    e_strm = (ms == 1) && mstrm;
    if (ms == 0) begin
      p = pick(req, -1);
      if (p >= 0) begin e_dbg[p] = 1'b1; grant = 1; end
    end else if (ms == 1) begin
      bit need = (mbeat > 0) || (mage[mown] >= (mstrm ? RS : RS - 1));
      if (!rdy) n_wait++;
      if (rdy && need) begin
        e_ta = 1;
        if (mbeat == 0 && mstrm && mage[mown] == RS) hit_str++;
        if (mbeat == 0 && !mstrm && mage[mown] == RS - 1) hit_std++;
        fin = mburst ? (mbeat == BTS - 1) : 1'b1;
        if (fin) begin
          e_cmp[mown] = 1'b1;
          if (!mburst) n_single++;
          if (mrd && mburst) begin
            p = pick(req, mown);
            if (p >= 0 && rd[p] && bu[p]) begin e_dbg[p] = 1'b1; go_str = 1; end
          end
        end
      end
    end
    chk(dbg == e_dbg, "R2/R5/R6/R9 grant", dbg, e_dbg);
    chk(ta == e_ta, "R4/R7/R8 ack", ta, e_ta);
    chk(cmp == e_cmp, "R3 completion", cmp, e_cmp);
    chk(strm == e_strm, "R8 stream flag", strm, e_strm);
    @(posedge clk);
    for (int m = 0; m < N; m++)
      mage[m] = (!req[m] || e_cmp[m]) ? 0 : ((mage[m] < RS) ? mage[m] + 1 : RS);
    if (ms == 0 && grant) begin
      ms = 1; mown = p; mlast = p; mbeat = 0; mstrm = 0; mrd = rd[p]; mburst = bu[p];
    end else if (ms == 1 && e_ta) begin
      if (fin) begin
        if (go_str) begin
          ms = 1; mown = p; mlast = p; mbeat = 0; mstrm = 1; mrd = rd[p]; mburst = bu[p];
          n_stream++;
        end else begin
          ms = 2; n_gap++;
        end
      end else mbeat++;
    end else if (ms == 2) ms = 0;
    for (int m = 0; m < N; m++)
      if (e_cmp[m]) begin void'(qrd[m].pop_front()); void'(qbu[m].pop_front()); end
  endtask

  task automatic steps(int k);
    for (int i = 0; i < k; i++) step();
  endtask

  task automatic drain();
    for (int i = 0; i < 3000; i++) begin
      bit empty = 1;
      for (int m = 0; m < N; m++) if (qrd[m].size() > 0) empty = 0;
      if (empty && ms == 0) break;
      step();
    end
    steps(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    for (int m = 0; m < N; m++) mage[m] = 0;
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(dbg == '0 && !ta && cmp == '0 && !strm, "R1 reset outputs", {dbg, cmp, ta, strm}, 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(dbg == '0 && !ta && cmp == '0 && !strm, "R1 after release", {dbg, cmp, ta, strm}, 0);

    // chain of burst reads on all masters, no wait states
    rdy_mode = 0;
    for (int m = 0; m < N; m++) push(m, 1, 1);
    drain();

    // late request lands just before a streaming handoff: R8 edge
    push(0, 1, 1);
    steps(5);
    push(1, 1, 1);
    drain();

    // mixed types with wait states
    rdy_mode = 1;
    push(0, 1, 1); push(1, 0, 1); push(2, 1, 0); push(3, 1, 1);
    push(0, 1, 1); push(0, 1, 1);
    drain();

    // random traffic
    for (int i = 0; i < 60; i++) push($urandom % N, $urandom % 2, ($urandom % 3) != 0);
    drain();
    rdy_mode = 0;
    for (int i = 0; i < 40; i++) push($urandom % N, ($urandom % 4) != 0, ($urandom % 4) != 0);
    drain();

    chk(n_stream > 0, "R5 streaming handoffs seen", n_stream, 1);
    chk(n_gap > 0, "R6 plain handoffs seen", n_gap, 1);
    chk(n_wait > 0, "R4 wait states seen", n_wait, 1);
    chk(hit_std > 0, "R7 earliest standard first beat", hit_std, 1);
    chk(hit_str > 0, "R8 earliest streamed first beat", hit_str, 1);
    chk(n_single > 0, "R3 single-beat tenures seen", n_single, 1);
    report();
    $finish;
  end
endmodule